// File: doc/BRIEF.md
# Timer Compare Output Unit

This block holds a 16-bit compare value and checks it against a free-running timer on every clock. When the timer first becomes equal to the compare value, the block applies the action chosen by a 4-bit mode field to a single output latch. The action is one of: set the latch, clear it, invert it, or leave it alone. In the same cycle the block raises a sticky event flag. Only a clear strobe lowers that flag.

Writing the mode field also sets up the latch. The two single-level modes load the latch with the level opposite to the one their match will drive, so that the match produces a visible edge. Writing the all-zero (off) mode pulls the latch low. The block drives only the latch and the flag. Pin direction and pin multiplexing belong to the logic around it.

Top module: `cmp_out_unit`

## Requirements
- R1: After reset, `cmp_out` and `evt_flag` are 0, the mode is off (0000) and the compare value is 0.
- R2: The comparison uses the compare value held before the current edge. A compare write takes effect from the next cycle. A match is the first clock in which `tmr_val` equals that value. The match's results appear on the outputs right after that clock edge.
- R3: In mode 1001, a match sets `cmp_out` to 1.
- R4: In mode 1000, a match clears `cmp_out` to 0.
- R5: In mode 0010, a match inverts `cmp_out`.
- R6: In mode 1010, a match sets `evt_flag` and leaves `cmp_out` unchanged.
- R7: A match in any of the four modes 1000, 1001, 1010 or 0010 sets `evt_flag`. In every other mode, equality has no effect on either output.
- R8: `evt_flag` stays set until `flag_clr` is pulsed. If `flag_clr` and a match arrive in the same cycle, the flag stays set.
- R9: Writing mode 1000 loads `cmp_out` with 1. Writing mode 1001 loads it with 0.
- R10: Writing mode 0000 forces `cmp_out` to 0. Writing any mode other than 0000, 1000 or 1001 leaves `cmp_out` as it was.
- R11: In a cycle with a mode write, a match has no effect: no action is applied and no flag is set. The mode write and its latch preset take effect instead.
- R12: While `tmr_val` stays equal to the compare value, only the first cycle counts as a match. A new match needs at least one cycle of inequality first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_val | input | 16 | Current timer count |
| cmp_wr_en | input | 1 | Compare value write strobe |
| cmp_wr_data | input | 16 | New compare value |
| mode_wr_en | input | 1 | Mode field write strobe |
| mode_wr_data | input | 4 | New mode field |
| flag_clr | input | 1 | Event flag clear strobe |
| cmp_out | output | 1 | Compare output latch |
| evt_flag | output | 1 | Sticky match event flag |

## Verification
Every result of this block is registered exactly once. A match, a mode preset, a compare write and a flag clear all show on the outputs just after the clock edge that samples their inputs. A compare write is the exception: it first affects matching one edge later. The bench changes inputs only on falling edges and reads outputs on the next falling edge. At that point a behavioural model has applied the same edge, so every cycle is compared against the model. Fixed expected levels are also checked at the points each requirement names.

// File: rtl/cmp_out_unit.sv
module cmp_out_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tmr_val,
  input  logic         cmp_wr_en,
  input  logic [W-1:0] cmp_wr_data,
  input  logic         mode_wr_en,
  input  logic [3:0]   mode_wr_data,
  input  logic         flag_clr,
  output logic         cmp_out,
  output logic         evt_flag
);
  localparam logic [3:0] M_OFF  = 4'b0000;
  localparam logic [3:0] M_TOG  = 4'b0010;
  localparam logic [3:0] M_LOW  = 4'b1000;
  localparam logic [3:0] M_HIGH = 4'b1001;
  localparam logic [3:0] M_FLAG = 4'b1010;

  logic [W-1:0] cmp_q;
  logic [3:0]   mode_q;
  logic         eq_q;
  logic         out_d;

  wire eq    = (tmr_val == cmp_q);
  wire armed = (mode_q == M_TOG) || (mode_q == M_LOW) ||
               (mode_q == M_HIGH) || (mode_q == M_FLAG);
  wire hit   = eq && !eq_q && armed && !mode_wr_en;

  always_comb begin
    out_d = cmp_out;
    if (mode_wr_en) begin
      case (mode_wr_data)
        M_OFF:   out_d = 1'b0;
        M_LOW:   out_d = 1'b1;
        M_HIGH:  out_d = 1'b0;
        default: out_d = cmp_out;
      endcase
    end else if (hit) begin
      case (mode_q)
        M_LOW:   out_d = 1'b0;
        M_HIGH:  out_d = 1'b1;
        M_TOG:   out_d = !cmp_out;
        default: out_d = cmp_out;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      mode_q   <= M_OFF;
      eq_q     <= 1'b0;
      cmp_out  <= 1'b0;
      evt_flag <= 1'b0;
    end else begin
      if (cmp_wr_en)  cmp_q  <= cmp_wr_data;
      if (mode_wr_en) mode_q <= mode_wr_data;
      eq_q    <= eq;
      cmp_out <= out_d;
      if (hit)           evt_flag <= 1'b1;
      else if (flag_clr) evt_flag <= 1'b0;
    end
  end

  a_r9_preset_low_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_en && mode_wr_data == M_LOW) |=> cmp_out);
  a_r10_off_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr_en && mode_wr_data == M_OFF) |=> !cmp_out);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_flag && !flag_clr) |=> evt_flag);
  a_r6_flag_mode_holds_out: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_FLAG && !mode_wr_en) |=> $stable(cmp_out));
  a_r12_held_equal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (eq && eq_q && !mode_wr_en && !flag_clr) |=> ($stable(cmp_out) && $stable(evt_flag)));
  a_r3_high_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HIGH && eq && !eq_q && !mode_wr_en) |=> (cmp_out && evt_flag));
endmodule

// File: tb/cmp_out_unit_tb.sv
module cmp_out_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tmr_val = '0;
  logic        cmp_wr_en = 1'b0;
  logic [15:0] cmp_wr_data = '0;
  logic        mode_wr_en = 1'b0;
  logic [3:0]  mode_wr_data = '0;
  logic        flag_clr = 1'b0;
  logic        cmp_out, evt_flag;

  int total = 0;
  int fails = 0;
  string tag = "R1";

  int m_cmp, m_mode, m_out, m_flag, m_eqp;

  always #2 clk = ~clk;

  cmp_out_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_val(tmr_val),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .mode_wr_en(mode_wr_en), .mode_wr_data(mode_wr_data),
    .flag_clr(flag_clr), .cmp_out(cmp_out), .evt_flag(evt_flag)
  );

  always @(posedge clk) begin
    int eq, act, hit;
    if (!rst_n) begin
      m_cmp = 0; m_mode = 0; m_out = 0; m_flag = 0; m_eqp = 0;
    end else begin
      eq  = (int'(tmr_val) == m_cmp);
      act = (m_mode == 8 || m_mode == 9 || m_mode == 10 || m_mode == 2);
      hit = eq && !m_eqp && act && !mode_wr_en;
      m_eqp = eq;
      if (mode_wr_en) begin
        m_mode = int'(mode_wr_data);
        if (m_mode == 0) m_out = 0;
        else if (m_mode == 8) m_out = 1;
        else if (m_mode == 9) m_out = 0;
      end else if (hit) begin
        if (m_mode == 8) m_out = 0;
        else if (m_mode == 9) m_out = 1;
        else if (m_mode == 2) m_out = 1 - m_out;
      end
      if (hit) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (cmp_wr_en) m_cmp = int'(cmp_wr_data);
    end
  end

  task automatic chk(input int got, input int exp, input string what);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk(int'(cmp_out), m_out, "cmp_out vs model");
    chk(int'(evt_flag), m_flag, "evt_flag vs model");
    cmp_wr_en = 1'b0; mode_wr_en = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic expect_lv(input int o, input int f);
    chk(int'(cmp_out), o, "cmp_out level");
    chk(int'(evt_flag), f, "evt_flag level");
  endtask

  task automatic set_mode(input logic [3:0] m);
    mode_wr_en = 1'b1; mode_wr_data = m;
  endtask

  task automatic set_cmp(input logic [15:0] v);
    cmp_wr_en = 1'b1; cmp_wr_data = v;
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk); tmr_val = 16'd5;
    step(); step();
    rst_n = 1'b1;
    tag = "R1"; step(); expect_lv(0, 0);
    tmr_val = 16'd0; step(); expect_lv(0, 0);

    tag = "R9"; set_cmp(16'd100); tmr_val = 16'd98; set_mode(4'b1001); step(); expect_lv(0, 0);
    tag = "R3"; tmr_val = 16'd99; step(); expect_lv(0, 0);
    tmr_val = 16'd100; step(); expect_lv(1, 1);
    tag = "R12"; step(); step(); expect_lv(1, 1);
    tag = "R8"; flag_clr = 1'b1; step(); expect_lv(1, 0);
    step(); expect_lv(1, 0);

    tag = "R9"; set_mode(4'b1000); step(); expect_lv(1, 0);
    tag = "R12"; step(); expect_lv(1, 0);
    tag = "R4"; tmr_val = 16'd101; step();
    tmr_val = 16'd100; step(); expect_lv(0, 1);
    tag = "R8"; tmr_val = 16'd7; flag_clr = 1'b1; step(); expect_lv(0, 0);
    tmr_val = 16'd100; flag_clr = 1'b1; step(); expect_lv(0, 1);
    flag_clr = 1'b1; step(); expect_lv(0, 0);

    tag = "R5"; set_mode(4'b0010); tmr_val = 16'd50; step(); expect_lv(0, 0);
    tmr_val = 16'd100; step(); expect_lv(1, 1);
    step(); step(); expect_lv(1, 1);
    tmr_val = 16'd50; flag_clr = 1'b1; step();
    tmr_val = 16'd100; step(); expect_lv(0, 1);
    tmr_val = 16'd50; step();
    tmr_val = 16'd100; step(); expect_lv(1, 1);
    tag = "R10"; set_mode(4'b0010); tmr_val = 16'd3; flag_clr = 1'b1; step(); expect_lv(1, 0);

    tag = "R6"; set_mode(4'b1010); step();
    tmr_val = 16'd100; step(); expect_lv(1, 1);
    tmr_val = 16'd4; flag_clr = 1'b1; step(); expect_lv(1, 0);

    tag = "R7"; set_mode(4'b0101); step();
    tmr_val = 16'd100; step(); expect_lv(1, 0);
    tmr_val = 16'd4; step(); set_mode(4'b0001); step();
    tmr_val = 16'd100; step(); expect_lv(1, 0);

    tag = "R11"; tmr_val = 16'd99; set_mode(4'b1000); step(); expect_lv(1, 0);
    tmr_val = 16'd100; set_mode(4'b1001); step(); expect_lv(0, 0);
    step(); expect_lv(0, 0);

    tag = "R10"; tmr_val = 16'd1; set_mode(4'b1000); step(); expect_lv(1, 0);
    set_mode(4'b0000); step(); expect_lv(0, 0);
    tmr_val = 16'd100; step(); expect_lv(0, 0);

    tag = "R2"; set_mode(4'b1001); tmr_val = 16'd200; set_cmp(16'd200); step(); expect_lv(0, 0);
    step(); expect_lv(1, 1);
    set_mode(4'b0010); flag_clr = 1'b1; step();
    tmr_val = 16'd300; set_cmp(16'd301); step();
    tmr_val = 16'd301; step(); expect_lv(0, 1);

    for (int i = 0; i < 400; i++) begin
      tag = "R5";
      tmr_val = 16'(i % 37);
      if (i % 53 == 0) set_cmp(16'(i % 11));
      if (i % 97 == 5) set_mode(4'(i % 16));
      if (i % 13 == 0) flag_clr = 1'b1;
      step();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule